// File: doc/BRIEF.md
# External Event Rendezvous Channel

This block couples one asynchronous event request line to a single software process that waits for it. The raw request enters through a two-stage synchroniser. The block then detects the rising edge of the synchronised level and latches that edge as a pending event. A process claims the channel by pulsing a registration input. Only one claimant is accepted at a time, and any further claim is refused with a one-cycle reject pulse.

When a pending event and a claimant are both present, the block raises the acknowledge output and issues a one-cycle scheduling request toward the process scheduler. Acknowledge then stays high until the synchronised request is seen low, which closes a four-phase handshake. At that point the pending event and the ownership are both released.

A claimant registered as high priority gets a dispatch strobe a fixed number of cycles after the acknowledge rises. This happens only if no other high-priority work was flagged busy at that moment. A cancel input lets a claimant give up the channel before any rendezvous takes place.

Top module: `evt_channel_hs`

## Requirements
- R1: The request pin passes through two synchroniser flops and then an edge stage. If a claimant already owns the channel and the pin rises just before clock edge k, acknowledge and the scheduling request first read high after edge k+3.
- R2: An event is formed from a rising edge of the synchronised request, not from its level. A request held high produces only one event, and once that event is acknowledged, a new claimant sees no acknowledge until the pin falls and rises again.
- R3: Acknowledge is raised only on the clock edge after both a pending event and an owning claimant exist. While acknowledge is high, the channel reads as owned.
- R4: Only one claimant owns the channel at a time. A registration pulse while the channel is owned, including during acknowledge, leaves ownership unchanged and makes reg_nak high for exactly the following cycle.
- R5: With no claimant, acknowledge stays low and the event stays pending. A claimant registering later is acknowledged two edges after its registration pulse.
- R6: The scheduling request is high for exactly one cycle, the first cycle in which acknowledge is high.
- R7: The claimant's priority is taken from wait_hi_prio at registration. If it is high and hi_busy is low at the edge where acknowledge rises, dispatch is high for one cycle beginning 19 edges after that edge. Otherwise, no dispatch occurs for that rendezvous.
- R8: Acknowledge stays high until the synchronised request is low, and then falls at the same edge that releases ownership and clears the pending event. If the pin falls just before edge k, acknowledge reads low after edge k+2.
- R9: A cancel pulse while the channel is owned and no rendezvous is forming releases ownership with no acknowledge. A cancel pulse during acknowledge has no effect. A rendezvous that forms at the same edge as a cancel takes precedence over it.
- R10: After reset, evt_ack, sched_req, dispatch, chan_owned and reg_nak are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_req_pad | input | 1 | Raw asynchronous event request |
| wait_reg | input | 1 | One-cycle pulse: a process asks to wait on the channel |
| wait_hi_prio | input | 1 | Priority of the registering process, sampled with wait_reg |
| wait_cancel | input | 1 | One-cycle pulse: the owner withdraws its wait |
| hi_busy | input | 1 | Other high-priority work is running |
| evt_ack | output | 1 | Acknowledge of the four-phase handshake |
| sched_req | output | 1 | One-cycle request to schedule the waiting process |
| dispatch | output | 1 | Fixed-latency dispatch strobe for a high-priority waiter |
| chan_owned | output | 1 | A process currently owns the channel |
| reg_nak | output | 1 | One-cycle refusal of a registration |

## Verification
A lost pending flag shows as an acknowledge that never comes for a claimant that registers late. A pending flag that sets from a level rather than an edge shows as an acknowledge to a second claimant while the pin is still high. Either appears within two cycles of the registration pulse. A wrong ownership state shows as a missing or extra reject pulse, or as a chan_owned mismatch, on the next cycle. An error in the release condition shows as acknowledge falling before, or later than, three edges after the pin drops. An error in the countdown moves or removes the dispatch strobe, and the cycle-by-cycle reference catches this at the exact edge.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
  typedef enum logic [1:0] {
    CH_FREE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_ACK   = 2'd2
  } ch_state_e;

  localparam int unsigned DEF_SYNC_STAGES  = 2;
  localparam int unsigned DEF_DISPATCH_LAT = 19;
  localparam int unsigned DEF_RST_STAGES   = 2;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_n = async_in;
    end else begin : g_many
      always_comb chain_n = {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/evt_edge.sv
module evt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;
  logic prev_n;

  always_comb prev_n = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_n;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import evt_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic req_lvl,
  input  logic wait_reg,
  input  logic wait_hi,
  input  logic cancel,
  input  logic hi_busy,
  output logic ack,
  output logic sched,
  output logic owned,
  output logic nak,
  output logic launch
);
  ch_state_e state_q, state_n;
  logic      pend_q, pend_n;
  logic      hi_q, hi_n;
  logic      sched_q, sched_n;
  logic      nak_q, nak_n;
  logic      meet;
  logic      done;

  // rendezvous: a latched edge meets an armed owner
  assign meet = (state_q == CH_ARMED) && pend_q;
  // handshake closes once the synchronised request is low
  assign done = (state_q == CH_ACK) && !req_lvl;

  always_comb begin
    state_n = state_q;
    hi_n    = hi_q;
    sched_n = 1'b0;
    nak_n   = 1'b0;
    unique case (state_q)
      CH_FREE: begin
        if (wait_reg) begin
          state_n = CH_ARMED;
          hi_n    = wait_hi;
        end
      end
      CH_ARMED: begin
        nak_n = wait_reg;
        if (meet) begin
          state_n = CH_ACK;
          sched_n = 1'b1;
        end else if (cancel) begin
          state_n = CH_FREE;
        end
      end
      CH_ACK: begin
        nak_n = wait_reg;
        if (done) state_n = CH_FREE;
      end
      default: state_n = CH_FREE;
    endcase
  end

  always_comb begin
    pend_n = pend_q;
    if (done)      pend_n = 1'b0;
    else if (rise) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_FREE;
      pend_q  <= 1'b0;
      hi_q    <= 1'b0;
      sched_q <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      hi_q    <= hi_n;
      sched_q <= sched_n;
      nak_q   <= nak_n;
    end
  end

  assign launch = meet && hi_q && !hi_busy;
  assign ack    = (state_q == CH_ACK);
  assign owned  = (state_q != CH_FREE);
  assign sched  = sched_q;
  assign nak    = nak_q;
endmodule

// File: rtl/dispatch_timer.sv
module dispatch_timer #(
  parameter int unsigned LAT = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic strobe
);
  localparam int unsigned CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          stb_q, stb_n;
  logic          cnt_en;

  assign cnt_en = act_q && (cnt_q != '0);

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    stb_n = act_q && (cnt_q == '0);
    if (launch) begin
      act_n = 1'b1;
      cnt_n = LOAD;
    end else if (cnt_en) begin
      cnt_n = cnt_q - 1'b1;
    end else if (act_q) begin
      act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      stb_q <= stb_n;
    end
  end

  assign strobe = stb_q;
endmodule

// File: rtl/evt_channel_hs.sv
module evt_channel_hs
  import evt_chan_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
  parameter int unsigned DISPATCH_LAT = DEF_DISPATCH_LAT,
  parameter int unsigned RST_STAGES   = DEF_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_req_pad,
  input  logic wait_reg,
  input  logic wait_hi_prio,
  input  logic wait_cancel,
  input  logic hi_busy,
  output logic evt_ack,
  output logic sched_req,
  output logic dispatch,
  output logic chan_owned,
  output logic reg_nak
);
  logic core_rst_n;
  logic req_lvl;
  logic req_rise;
  logic launch;

  // asynchronous assertion, synchronous release
  evt_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(1'b1),
    .sync_out(core_rst_n)
  );

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .async_in(evt_req_pad),
    .sync_out(req_lvl)
  );

  evt_edge u_edge (
    .clk  (clk),
    .rst_n(core_rst_n),
    .lvl  (req_lvl),
    .rise (req_rise)
  );

  chan_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .rise    (req_rise),
    .req_lvl (req_lvl),
    .wait_reg(wait_reg),
    .wait_hi (wait_hi_prio),
    .cancel  (wait_cancel),
    .hi_busy (hi_busy),
    .ack     (evt_ack),
    .sched   (sched_req),
    .owned   (chan_owned),
    .nak     (reg_nak),
    .launch  (launch)
  );

  dispatch_timer #(.LAT(DISPATCH_LAT)) u_disp (
    .clk   (clk),
    .rst_n (core_rst_n),
    .launch(launch),
    .strobe(dispatch)
  );
endmodule

// File: rtl/evt_channel_chk.sv
module evt_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_ack,
  input logic sched_req,
  input logic chan_owned,
  input logic reg_nak,
  input logic req_lvl
);
  AST_ACK_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack |-> chan_owned); // R3
  AST_ACK_RISE_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_ack) |-> $past(chan_owned)); // R3
  AST_NAK_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_nak |-> $past(chan_owned)); // R4
  AST_SCHED_AT_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sched_req |-> (evt_ack && !$past(evt_ack))); // R6
  AST_SCHED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sched_req |=> !sched_req); // R6
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_ack) |-> !$past(req_lvl)); // R8
  AST_RELEASE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_ack) |-> !chan_owned); // R8
endmodule

bind evt_channel_hs evt_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_ack   (evt_ack),
  .sched_req (sched_req),
  .chan_owned(chan_owned),
  .reg_nak   (reg_nak),
  .req_lvl   (req_lvl)
);

// File: tb/sim_evt_channel_hs.sv
`timescale 1ns/1ps
module sim_evt_channel_hs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad = 1'b0, wreg = 1'b0, whi = 1'b0, wcan = 1'b0, hbusy = 1'b0;
  logic evt_ack, sched_req, dispatch, chan_owned, reg_nak;

  always #2 clk = ~clk;

  evt_channel_hs u0 (
    .clk(clk), .rst_n(rst_n), .evt_req_pad(pad), .wait_reg(wreg),
    .wait_hi_prio(whi), .wait_cancel(wcan), .hi_busy(hbusy),
    .evt_ack(evt_ack), .sched_req(sched_req), .dispatch(dispatch),
    .chan_owned(chan_owned), .reg_nak(reg_nak)
  );

  // behavioural reference
  int  hist[$];
  bit  m_owned, m_acking, m_pend, m_hi, m_sched, m_nak, m_disp;
  int  m_cd;
  bit  t_lvl, t_rise, t_was_owned, t_launch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_owned = 0; m_acking = 0; m_pend = 0; m_hi = 0;
      m_sched = 0; m_nak = 0; m_disp = 0; m_cd = -1;
    end else begin
      t_lvl = (hist[1] != 0);
      t_rise = (hist[1] != 0) && (hist[2] == 0);
      t_was_owned = m_owned;
      t_launch = 0;
      m_sched = 0;
      m_nak = 0;
      m_disp = (m_cd == 0);
      if (m_acking) begin
        if (!t_lvl) begin m_acking = 0; m_owned = 0; m_pend = 0; end
      end else if (m_owned) begin
        if (m_pend) begin
          m_acking = 1; m_sched = 1; t_launch = m_hi && !hbusy;
        end else if (wcan) m_owned = 0;
      end
      if (wreg) begin
        if (t_was_owned) m_nak = 1;
        else begin m_owned = 1; m_hi = whi; end
      end
      if (t_rise) m_pend = 1;
      if (t_launch) m_cd = 18;
      else if (m_cd > 0) m_cd = m_cd - 1;
      else if (m_cd == 0) m_cd = -1;
      hist.push_front(pad ? 1 : 0);
      void'(hist.pop_back());
    end
  end

  int n_cmp = 0, n_bad = 0;
  string cur = "R10";

  task automatic chk(input string nm, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("evt_ack", evt_ack, m_acking);
      chk("sched_req", sched_req, m_sched);
      chk("dispatch", dispatch, m_disp);
      chk("chan_owned", chan_owned, m_owned);
      chk("reg_nak", reg_nak, m_nak);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic claim(input bit hi);
    @(negedge clk); wreg = 1; whi = hi;
    @(negedge clk); wreg = 0; whi = 0;
  endtask

  task automatic drop_claim();
    @(negedge clk); wcan = 1;
    @(negedge clk); wcan = 0;
  endtask

  bit done = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    cur = "R10";
    tick(4);
    // R1 and R6: owner first, then edge; R8: release after pin drops
    cur = "R1";
    claim(1);
    @(negedge clk); pad = 1;
    tick(6);
    cur = "R8";
    pad = 0;
    tick(5);
    // R7: high-priority waiter, dispatch 19 edges later
    cur = "R7";
    tick(20);
    // R5: event with no owner stays pending
    cur = "R5";
    @(negedge clk); pad = 1;
    tick(2); pad = 0;
    tick(10);
    claim(0);
    tick(6);
    // R2: level held high gives a single event
    cur = "R2";
    @(negedge clk); pad = 1;
    tick(5);
    claim(0);
    tick(5);
    claim(0);
    tick(8);
    pad = 0;
    tick(5);
    claim(0);
    tick(8);
    drop_claim();
    tick(3);
    // R4: second registration refused
    cur = "R4";
    claim(1);
    claim(0);
    tick(2);
    @(negedge clk); wreg = 1;
    tick(3); wreg = 0;
    tick(2);
    // R9: cancel releases without ack, cancel during ack ignored
    cur = "R9";
    drop_claim();
    @(negedge clk); pad = 1;
    tick(6); pad = 0;
    tick(4);
    claim(0);
    tick(3);
    drop_claim();
    tick(3);
    claim(0);
    @(negedge clk); pad = 1;
    tick(3); wcan = 1;
    tick(2); wcan = 0;
    tick(3); pad = 0;
    tick(6);
    // R7: busy high-priority work and low priority waiter get no dispatch
    cur = "R7";
    hbusy = 1;
    claim(1);
    @(negedge clk); pad = 1;
    tick(6); pad = 0;
    tick(25);
    hbusy = 0;
    claim(0);
    @(negedge clk); pad = 1;
    tick(6); pad = 0;
    tick(25);
    // R3: short pulse, late claim, ack for one cycle past release
    cur = "R3";
    @(negedge clk); pad = 1;
    @(negedge clk); pad = 0;
    tick(6);
    claim(1);
    tick(26);
    // R6: back-to-back rendezvous
    cur = "R6";
    claim(1);
    @(negedge clk); pad = 1;
    tick(5); pad = 0;
    tick(3);
    claim(1);
    @(negedge clk); pad = 1;
    tick(5); pad = 0;
    tick(30);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule